// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block lives inside an SDRAM controller and takes the memory into and out of self-refresh when the controller core asks. From idle, an accepted entry request can first run a burst of auto-refresh commands. It then issues the self-refresh command with CKE low and stops the memory clock through an enable output. The block keeps the device in self-refresh until an exit request arrives and the minimum residency time has passed.

On exit, the block restarts the clock and waits a set number of stable cycles. It then raises CKE with the chip deselected and waits out the refresh recovery time. If burst mode was selected, it runs a second auto-refresh burst. One-cycle acknowledge pulses tell the core when entry and exit are complete. The timing windows come from picosecond parameters and the clock period, rounded up to whole cycles. The clock-stable wait is given directly in cycles.

Command encoding on (cs_n, ras_n, cas_n, we_n) is as follows. Refresh is 0,0,0,1, and it means auto-refresh with CKE high or self-refresh entry with CKE low. NOP is 1,1,1,1.

Top module: `sref_seq`

## Requirements
- R1: Out of reset, mem_cke, mem_clk_en, mem_cs_n, mem_ras_n, mem_cas_n and mem_we_n are all high, and both acknowledges are low.
- R2: The self-refresh command is refresh code 0,0,0,1 with mem_cke driven low in that same cycle. Without burst mode it appears one cycle after the entry request is sampled in idle.
- R3: mem_clk_en stays high in the cycle after the entry command. It goes low two cycles after that command, and enter_ack pulses for exactly that one cycle.
- R4: While in self-refresh, mem_cke stays low and mem_clk_en stays low until the exit sequence starts. Every cycle that is not a refresh command drives NOP.
- R5: mem_clk_en rises no earlier than TRAS_C cycles after the entry command, with TRAS_C = ceil(T_RAS_PS/CLK_PS) and TRAS_C >= 3 assumed. An exit request sampled from the entry-command cycle onward is remembered and acted on once that window has passed. Otherwise the clock rises the cycle after the request.
- R6: mem_cke rises exactly CKSTB_CYC cycles after mem_clk_en rises, with mem_cs_n high in that cycle.
- R7: Without burst mode, exit_ack pulses exactly TRFC_C = ceil(T_RFC_PS/CLK_PS) cycles after mem_cke rises, and no command is issued before it.
- R8: In burst mode, BURST_LEN auto-refresh commands (0,0,0,1 with CKE high) start one cycle after the entry request. They are spaced exactly TRFC_C cycles apart, and the self-refresh command follows the last one TRFC_C cycles later.
- R9: In burst mode, the first post-exit auto-refresh comes TRFC_C cycles after mem_cke rises. BURST_LEN of them follow at TRFC_C spacing, and exit_ack comes TRFC_C cycles after the last one.
- R10: burst_mode is sampled only when an entry request is accepted, and that value governs both the entry and the exit bursts.
- R11: An entry request outside idle is ignored, and so is an exit request before the self-refresh command is issued. Neither produces any command, clock or CKE change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request self-refresh entry (sampled in idle) |
| exit_req | input | 1 | Request self-refresh exit |
| burst_mode | input | 1 | Wrap entry and exit with refresh bursts |
| enter_ack | output | 1 | One-cycle pulse: entry complete |
| exit_ack | output | 1 | One-cycle pulse: exit complete |
| mem_clk_en | output | 1 | Memory clock gate enable |
| mem_cke | output | 1 | Memory clock enable pin |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is an exit request that arrives while the residency window is still open, and especially one that lands on the entry-command or clock-hold cycle. It must be remembered rather than dropped or acted on early. The bench sweeps the exit request offset across every cycle from the entry command to past the end of the window. It does this in both burst settings and predicts each clock restart as the later of request+1 and entry+TRAS_C. In the same runs, stray requests arrive during the pre-entry burst and during the hold cycle, and burst_mode is flipped mid-residency.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REF,
        ST_ENTER,
        ST_HOLD,
        ST_SELF,
        ST_WAKE,
        ST_RECOVER,
        ST_POST_REF
    } sref_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP = 4'b1111;
    localparam dram_cmd_t CMD_REF = 4'b0001;

    typedef struct packed {
        sref_state_e st;
        dram_cmd_t   cmd;
        logic        cke;
        logic        clk_en;
        logic        burst;
        logic        exit_pend;
        logic        ent_ack;
        logic        ex_ack;
    } sref_ctl_t;

    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (zero && !load) |=> zero); // R5

endmodule

// File: rtl/sref_burst_ctr.sv
module sref_burst_ctr #(
    parameter int N = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);

    localparam int W = (N > 1) ? $clog2(N) : 1;

    logic [W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load) begin
            left_d = W'(N - 1);
        end else if (step && left_q != '0) begin
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign last = (left_q == '0);

    AST_BURST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n) (last && !load) |=> last); // R8

endmodule

// File: rtl/sref_seq.sv
module sref_seq
    import sref_pkg::*;
#(
    parameter int CLK_PS    = 4000,
    parameter int T_RAS_PS  = 42000,
    parameter int T_RFC_PS  = 63000,
    parameter int CKSTB_CYC = 4,
    parameter int BURST_LEN = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    input  logic burst_mode,
    output logic enter_ack,
    output logic exit_ack,
    output logic mem_clk_en,
    output logic mem_cke,
    output logic mem_cs_n,
    output logic mem_ras_n,
    output logic mem_cas_n,
    output logic mem_we_n
);

    localparam int TRAS_C = ps_to_cycles(T_RAS_PS, CLK_PS);
    localparam int TRFC_C = ps_to_cycles(T_RFC_PS, CLK_PS);
    localparam int STB_C  = (CKSTB_CYC < 1) ? 1 : CKSTB_CYC;
    localparam int MAX_A  = (TRAS_C > TRFC_C) ? TRAS_C : TRFC_C;
    localparam int MAX_C  = (MAX_A > STB_C) ? MAX_A : STB_C;
    localparam int TW     = $clog2(MAX_C + 1);

    localparam logic [TW-1:0] LD_RAS = TW'(TRAS_C - 1);
    localparam logic [TW-1:0] LD_RFC = TW'(TRFC_C - 1);
    localparam logic [TW-1:0] LD_STB = TW'(STB_C - 1);

    sref_ctl_t ctl_d, ctl_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          bc_load;
    logic          bc_step;
    logic          bc_last;

    sref_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sref_burst_ctr #(.N(BURST_LEN)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bc_load),
        .step  (bc_step),
        .last  (bc_last)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.cmd     = CMD_NOP;
        ctl_d.ent_ack = 1'b0;
        ctl_d.ex_ack  = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        bc_load       = 1'b0;
        bc_step       = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.exit_pend = 1'b0;
                if (enter_req) begin
                    ctl_d.burst = burst_mode;
                    ctl_d.cmd   = CMD_REF;
                    tmr_load    = 1'b1;
                    if (burst_mode) begin
                        tmr_val  = LD_RFC;
                        bc_load  = 1'b1;
                        ctl_d.st = ST_PRE_REF;
                    end else begin
                        tmr_val   = LD_RAS;
                        ctl_d.cke = 1'b0;
                        ctl_d.st  = ST_ENTER;
                    end
                end
            end
            ST_PRE_REF: begin
                if (tmr_zero) begin
                    ctl_d.cmd = CMD_REF;
                    tmr_load  = 1'b1;
                    if (!bc_last) begin
                        tmr_val = LD_RFC;
                        bc_step = 1'b1;
                    end else begin
                        tmr_val   = LD_RAS;
                        ctl_d.cke = 1'b0;
                        ctl_d.st  = ST_ENTER;
                    end
                end
            end
            ST_ENTER: begin
                ctl_d.exit_pend = ctl_q.exit_pend | exit_req;
                ctl_d.st        = ST_HOLD;
            end
            ST_HOLD: begin
                ctl_d.exit_pend = ctl_q.exit_pend | exit_req;
                ctl_d.clk_en    = 1'b0;
                ctl_d.ent_ack   = 1'b1;
                ctl_d.st        = ST_SELF;
            end
            ST_SELF: begin
                if ((ctl_q.exit_pend || exit_req) && tmr_zero) begin
                    ctl_d.exit_pend = 1'b0;
                    ctl_d.clk_en    = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_val         = LD_STB;
                    ctl_d.st        = ST_WAKE;
                end else begin
                    ctl_d.exit_pend = ctl_q.exit_pend | exit_req;
                end
            end
            ST_WAKE: begin
                if (tmr_zero) begin
                    ctl_d.cke = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RFC;
                    ctl_d.st  = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) begin
                    if (ctl_q.burst) begin
                        ctl_d.cmd = CMD_REF;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_RFC;
                        bc_load   = 1'b1;
                        ctl_d.st  = ST_POST_REF;
                    end else begin
                        ctl_d.ex_ack = 1'b1;
                        ctl_d.st     = ST_IDLE;
                    end
                end
            end
            ST_POST_REF: begin
                if (tmr_zero) begin
                    if (!bc_last) begin
                        ctl_d.cmd = CMD_REF;
                        tmr_load  = 1'b1;
                        tmr_val   = LD_RFC;
                        bc_step   = 1'b1;
                    end else begin
                        ctl_d.ex_ack = 1'b1;
                        ctl_d.st     = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.cmd       <= CMD_NOP;
            ctl_q.cke       <= 1'b1;
            ctl_q.clk_en    <= 1'b1;
            ctl_q.burst     <= 1'b0;
            ctl_q.exit_pend <= 1'b0;
            ctl_q.ent_ack   <= 1'b0;
            ctl_q.ex_ack    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign enter_ack  = ctl_q.ent_ack;
    assign exit_ack   = ctl_q.ex_ack;
    assign mem_clk_en = ctl_q.clk_en;
    assign mem_cke    = ctl_q.cke;
    assign mem_cs_n   = ctl_q.cmd.cs_n;
    assign mem_ras_n  = ctl_q.cmd.ras_n;
    assign mem_cas_n  = ctl_q.cmd.cas_n;
    assign mem_we_n   = ctl_q.cmd.we_n;

    // Observation counters for the timing assertions
    logic        ref_on_pins;
    logic [15:0] sr_age_q;
    logic [15:0] rfc_gap_q;

    assign ref_on_pins = !mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_age_q  <= '0;
            rfc_gap_q <= '1;
        end else begin
            if (mem_cke) sr_age_q <= '0;
            else if (sr_age_q != '1) sr_age_q <= sr_age_q + 1'b1;
            if (ref_on_pins || (mem_cke && !$past(mem_cke))) rfc_gap_q <= 16'd1;
            else if (rfc_gap_q != '1) rfc_gap_q <= rfc_gap_q + 1'b1;
        end
    end

    AST_SREF_WITH_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_cke) |-> ref_on_pins); // R2
    AST_ENTER_ACK_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n) enter_ack |-> (!mem_clk_en && $past(mem_clk_en))); // R3
    AST_CLK_OFF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !mem_clk_en |-> !mem_cke); // R4
    AST_TRAS_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_clk_en) |-> (sr_age_q >= 16'(TRAS_C))); // R5
    AST_CKE_RISE_DESEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_cke) |-> (mem_cs_n && $past(mem_clk_en))); // R6
    AST_ACKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({enter_ack, exit_ack})); // R7
    AST_TRFC_GAP: assert property (@(posedge clk) disable iff (!rst_n) ref_on_pins |-> (rfc_gap_q >= 16'(TRFC_C))); // R8

endmodule

// File: tb/sref_seq_bench.sv
module sref_seq_bench;

    localparam int CLK_PS   = 4000;
    localparam int RAS_PS   = 24000;
    localparam int RFC_PS   = 10000;
    localparam int CKSTB    = 4;
    localparam int BLEN     = 5;
    localparam int TRAS_E   = (RAS_PS + CLK_PS - 1) / CLK_PS;
    localparam int TRFC_E   = (RFC_PS + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0;
    logic exit_req = 1'b0;
    logic burst_mode = 1'b0;
    logic enter_ack, exit_ack, mem_clk_en, mem_cke;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;

    always #2 clk = ~clk;

    sref_seq #(
        .CLK_PS(CLK_PS), .T_RAS_PS(RAS_PS), .T_RFC_PS(RFC_PS),
        .CKSTB_CYC(CKSTB), .BURST_LEN(BLEN)
    ) u_sref_seq (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .burst_mode(burst_mode), .enter_ack(enter_ack), .exit_ack(exit_ack),
        .mem_clk_en(mem_clk_en), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // negedge monitor of the pins
    int ar_pre[16];
    int ar_post[16];
    int n_pre, n_post, n_sref, sref_at, n_other;
    int n_clk_fall, clk_lo_at, n_clk_rise, clk_hi_at;
    int n_cke_fall, n_cke_rise, cke_hi_at, cs_at_rise;
    int n_eack, eack_at, n_xack, xack_at;
    logic phase_sr;
    logic prev_cke = 1'b1;
    logic prev_clk = 1'b1;

    task automatic clear_mon();
        n_pre = 0; n_post = 0; n_sref = 0; sref_at = -1; n_other = 0;
        n_clk_fall = 0; clk_lo_at = -1; n_clk_rise = 0; clk_hi_at = -1;
        n_cke_fall = 0; n_cke_rise = 0; cke_hi_at = -1; cs_at_rise = -1;
        n_eack = 0; eack_at = -1; n_xack = 0; xack_at = -1;
        phase_sr = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_ras_n && !mem_cas_n && mem_we_n) begin
                if (!mem_cke) begin
                    n_sref++; sref_at = cyc; phase_sr = 1'b1;
                end else if (!phase_sr) begin
                    if (n_pre < 16) ar_pre[n_pre] = cyc;
                    n_pre++;
                end else begin
                    if (n_post < 16) ar_post[n_post] = cyc;
                    n_post++;
                end
            end else if (!(mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n)) begin
                n_other++;
            end
            if (prev_clk && !mem_clk_en) begin n_clk_fall++; clk_lo_at = cyc; end
            if (!prev_clk && mem_clk_en) begin n_clk_rise++; clk_hi_at = cyc; end
            if (prev_cke && !mem_cke) n_cke_fall++;
            if (!prev_cke && mem_cke) begin n_cke_rise++; cke_hi_at = cyc; cs_at_rise = int'(mem_cs_n); end
            if (enter_ack) begin n_eack++; eack_at = cyc; end
            if (exit_ack) begin n_xack++; xack_at = cyc; end
            prev_cke = mem_cke;
            prev_clk = mem_clk_en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One full entry/exit pass; exit request offset eoff from the entry command
    task automatic scenario(input logic b, input int eoff);
        int c0, s, e, w, c, xa, last;
        @(posedge clk); #1 clear_mon();
        @(negedge clk);
        c0 = cyc;
        s  = c0 + 1 + (b ? BLEN * TRFC_E : 0);
        e  = s + eoff;
        w  = (e + 1 > s + TRAS_E) ? e + 1 : s + TRAS_E;
        c  = w + CKSTB;
        xa = c + TRFC_E + (b ? BLEN * TRFC_E : 0);
        last = xa + 3;
        while (cyc <= last) begin
            enter_req  = (cyc == c0) || (cyc == s + 1);
            exit_req   = (cyc == c0) || (cyc == e) || (b && cyc == s - 2);
            burst_mode = (cyc >= s + 1) ? !b : b;
            @(negedge clk);
        end
        enter_req = 1'b0; exit_req = 1'b0; burst_mode = 1'b0;
        // R8 / R2: pre-entry sequence
        chk("R8 pre-burst count", n_pre, b ? BLEN : 0);
        for (int k = 0; k < BLEN && k < n_pre; k++)
            chk("R8 pre-burst spacing", ar_pre[k], c0 + 1 + k * TRFC_E);
        chk("R2 one self-refresh command", n_sref, 1);
        chk("R2 self-refresh cycle", sref_at, s);
        chk("R2 single CKE fall", n_cke_fall, 1);
        chk("R3 clock stop cycle", clk_lo_at, s + 2);
        chk("R3 enter_ack count", n_eack, 1);
        chk("R3 enter_ack cycle", eack_at, s + 2);
        chk("R4 single clock stop", n_clk_fall, 1);
        chk("R4 no foreign command", n_other, 0);
        chk("R5 clock restart cycle", clk_hi_at, w);
        chk("R11 single clock restart", n_clk_rise, 1);
        chk("R6 CKE rise cycle", cke_hi_at, c);
        chk("R6 CKE rise count", n_cke_rise, 1);
        chk("R6 deselected at CKE rise", cs_at_rise, 1);
        chk("R10 post-burst count", n_post, b ? BLEN : 0);
        for (int k = 0; k < BLEN && k < n_post; k++)
            chk("R9 post-burst spacing", ar_post[k], c + TRFC_E + k * TRFC_E);
        chk("R7 exit_ack count", n_xack, 1);
        chk("R7 exit_ack cycle", xack_at, xa);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cke", int'(mem_cke), 1);
        chk("R1 clk_en", int'(mem_clk_en), 1);
        chk("R1 command NOP", int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 15);
        chk("R1 acks low", int'({enter_ack, exit_ack}), 0);
        // R11: exit request in idle does nothing
        @(posedge clk); #1 clear_mon();
        @(negedge clk); exit_req = 1'b1;
        @(negedge clk); exit_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 idle exit: no command", n_pre + n_sref + n_other, 0);
        chk("R11 idle exit: no CKE change", n_cke_fall, 0);
        chk("R11 idle exit: clock kept", n_clk_fall, 0);
        chk("R11 idle exit: no ack", n_xack + n_eack, 0);
        for (int b = 0; b < 2; b++)
            for (int off = 0; off <= TRAS_E + 2; off++)
                scenario(logic'(b), off);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule